// File: doc/BRIEF.md
# PHY PLL Divider Search Engine

This block works out the divider settings for a PHY's PLL. It takes a target lane clock rate and a reference clock rate, both as integers in kHz. It searches a window of candidate input dividers and keeps the one whose feedback product leaves the smallest remainder against the reference. From the chosen pair it produces the register bytes a PHY setup sequence writes: the input-divider byte, a two-byte split feedback-divider encoding, a frequency-band byte and a VCO range byte. It also reports the rate those dividers actually give. Sending the bytes to the PHY is left to other logic.

The engine is iterative. One restoring divider is shared by every quotient and remainder the engine needs, one at a time: the window limits, the VCO step, each search candidate, the final feedback divider and the achieved rate. A one-cycle `start` pulse while idle launches a run. `busy` stays high while the run is in progress, and a one-cycle `done` pulse marks the cycle in which every output and error flag is valid. Two conditions end a run early with an error flag set: a target above the highest band, and a reference that leaves the divider window empty.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `busy`, `done`, both error flags and every output byte and rate are zero.
- R2: A `start` pulse seen while the engine is idle makes `busy` or `done` high in the following cycle. `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R3: Let the target in whole MHz be floor(tgt/1000). If it exceeds 1500, `err_range` is set and `done` comes one cycle after `start`, with no search run. Otherwise `err_range` is clear.
- R4: Let lo = floor(ref/40000)+1 and hi = floor(ref/5000). When hi < lo (a zero reference included), `err_ref` is set and no divider outputs are produced.
- R5: Candidates p run upward from lo while p < hi. A candidate is kept when (tgt*p mod ref) is strictly below the best remainder so far and floor(tgt*p/ref) < 512. The best remainder starts at ref and the chosen divider starts at 1. `pre_byte` = chosen divider minus 1, in 8 bits.
- R6: With fb = floor(tgt*p/ref) for the chosen p, `fb_lo_byte` = (fb-1) & 0x1F and `fb_hi_byte` = (((fb-1) >> 5) | 0x80) & 0xFF.
- R7: `band_byte` is the code of the first band whose upper limit in MHz is not below floor(tgt/1000), shifted left by one. The band limits and codes run, in ascending order: 90:01 100:10 110:20 130:01 140:11 150:21 170:02 180:12 200:22 220:03 240:13 250:23 270:04 300:14 330:05 360:15 400:25 450:06 500:16 550:07 600:17 650:08 700:18 750:09 800:19 850:29 900:39 950:0a 1000:1a 1050:2a 1100:3a 1150:0b 1200:1b 1250:2b 1300:3b 1350:0c 1400:1c 1450:2c 1500:3c (hex codes).
- R8: `vco_byte` = 0x80 | (floor(tgt/200000) << 3) | 0x3, truncated to 8 bits.
- R9: `rate_khz` = floor(ref*fb/p), the rate the chosen dividers give.
- R10: When the window holds no candidate (lo = hi), the chosen divider is 1 and `pre_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when the engine is idle |
| tgt_khz | input | FW | Target lane clock rate in kHz |
| ref_khz | input | FW | Reference clock rate in kHz |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse, outputs valid |
| err_ref | output | 1 | Divider window empty |
| err_range | output | 1 | Target above the highest band |
| pre_byte | output | 8 | Input divider minus one |
| fb_lo_byte | output | 8 | Low five bits of feedback divider minus one |
| fb_hi_byte | output | 8 | Upper bits of feedback divider minus one, bit 7 set |
| band_byte | output | 8 | Band code shifted left by one |
| vco_byte | output | 8 | VCO range byte |
| rate_khz | output | FW | Achieved rate in kHz |

## Verification
The hardest cases to reach are the selection edges of the search. One is a later candidate that ties the best remainder and so must be rejected. Another is a window that holds no candidate at all, so the default divider has to come through. The third is a window that is empty in the inverted sense and must raise the reference error. The stimulus reaches these by choosing reference rates directly: exactly 5 MHz gives a window holding no candidate, just under 5 MHz or zero gives the error, and references of 24 to 100 MHz give windows several candidates long. Targets are placed on band edges (90.999 MHz, 91 MHz, 1500.999 MHz and 1501 MHz) to exercise the inclusive limit.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_VCO, S_SRCH, S_FIN, S_RATE, S_DONE
  } ph_t;

  localparam int unsigned BAND_N = 39;

  // {upper limit in MHz (11 bits), band code (6 bits)}
  function automatic logic [16:0] band_ent(input int k);
    case (k)
      0:  return {11'd90,   6'h01};  1:  return {11'd100,  6'h10};
      2:  return {11'd110,  6'h20};  3:  return {11'd130,  6'h01};
      4:  return {11'd140,  6'h11};  5:  return {11'd150,  6'h21};
      6:  return {11'd170,  6'h02};  7:  return {11'd180,  6'h12};
      8:  return {11'd200,  6'h22};  9:  return {11'd220,  6'h03};
      10: return {11'd240,  6'h13};  11: return {11'd250,  6'h23};
      12: return {11'd270,  6'h04};  13: return {11'd300,  6'h14};
      14: return {11'd330,  6'h05};  15: return {11'd360,  6'h15};
      16: return {11'd400,  6'h25};  17: return {11'd450,  6'h06};
      18: return {11'd500,  6'h16};  19: return {11'd550,  6'h07};
      20: return {11'd600,  6'h17};  21: return {11'd650,  6'h08};
      22: return {11'd700,  6'h18};  23: return {11'd750,  6'h09};
      24: return {11'd800,  6'h19};  25: return {11'd850,  6'h29};
      26: return {11'd900,  6'h39};  27: return {11'd950,  6'h0a};
      28: return {11'd1000, 6'h1a};  29: return {11'd1050, 6'h2a};
      30: return {11'd1100, 6'h3a};  31: return {11'd1150, 6'h0b};
      32: return {11'd1200, 6'h1b};  33: return {11'd1250, 6'h2b};
      34: return {11'd1300, 6'h3b};  35: return {11'd1350, 6'h0c};
      36: return {11'd1400, 6'h1c};  37: return {11'd1450, 6'h2c};
      default: return {11'd1500, 6'h3c};
    endcase
  endfunction

endpackage

// File: rtl/pll_band_lut.sv
module pll_band_lut
  import pll_div_pkg::*;
#(
  parameter int unsigned FW = 21
) (
  input  logic [FW-1:0] tgt_khz,
  output logic          hit,
  output logic [5:0]    code
);

  logic [BAND_N-1:0] in_band;
  logic [5:0]        code_k [BAND_N];

  for (genvar k = 0; k < BAND_N; k++) begin : g_band
    localparam logic [16:0] ENT = band_ent(k);
    // floor(tgt/1000) <= limit  <=>  tgt < (limit+1)*1000
    assign in_band[k] = ({{(32-FW){1'b0}}, tgt_khz} <
                         ((32'(ENT[16:6]) + 32'd1) * 32'd1000));
    assign code_k[k]  = ENT[5:0];
  end

  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int k = BAND_N - 1; k >= 0; k--) begin
      if (in_band[k]) begin
        hit  = 1'b1;
        code = code_k[k];
      end
    end
  end

endmodule

// File: rtl/pll_divu.sv
module pll_divu #(
  parameter int unsigned NW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo,
  output logic [NW-1:0] rem
);

  localparam int unsigned CW = $clog2(NW + 1);

  logic [NW-1:0] acc_q, acc_d, qs_q, qs_d, den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, fin_q, fin_d;
  logic [NW:0]   trial;
  logic          ge;

  assign trial = {acc_q, qs_q[NW-1]};
  assign ge    = (trial >= {1'b0, den_q});

  always_comb begin
    acc_d = acc_q;
    qs_d  = qs_q;
    den_d = den_q;
    cnt_d = cnt_q;
    run_d = run_q;
    fin_d = 1'b0;
    if (go) begin
      acc_d = '0;
      qs_d  = num;
      den_d = den;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      acc_d = ge ? NW'(trial - {1'b0, den_q}) : trial[NW-1:0];
      qs_d  = {qs_q[NW-2:0], ge};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      qs_q  <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      qs_q  <= qs_d;
      den_q <= den_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign fin = fin_q;
  assign quo = qs_q;
  assign rem = acc_q;

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_div_pkg::*;
#(
  parameter int unsigned FW           = 21,
  parameter int unsigned PW           = 10,
  parameter int unsigned FB_LIMIT     = 512,
  parameter int unsigned PFD_MIN_KHZ  = 5000,
  parameter int unsigned PFD_MAX_KHZ  = 40000,
  parameter int unsigned VCO_STEP_KHZ = 200000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] tgt_khz,
  input  logic [FW-1:0] ref_khz,
  output logic          busy,
  output logic          done,
  output logic          err_ref,
  output logic          err_range,
  output logic [7:0]    pre_byte,
  output logic [7:0]    fb_lo_byte,
  output logic [7:0]    fb_hi_byte,
  output logic [7:0]    band_byte,
  output logic [7:0]    vco_byte,
  output logic [FW-1:0] rate_khz
);

  localparam int unsigned NW = FW + PW;

  ph_t           st_q, st_d;
  logic          kick_q, kick_d;
  logic [FW-1:0] tgt_q, tgt_d, ref_q, ref_d, best_q, best_d, fb_q, fb_d;
  logic [PW-1:0] pmin_q, pmin_d, pmax_q, pmax_d, idx_q, idx_d, pbest_q, pbest_d;
  logic          erf_q, erf_d, ern_q, ern_d;
  logic [7:0]    pre_q, pre_d, fbl_q, fbl_d, fbh_q, fbh_d;
  logic [7:0]    band_q, band_d, vco_q, vco_d;
  logic [FW-1:0] rate_q, rate_d;
  logic [NW-1:0] num, den, quo, rem;
  logic          fin, band_hit;
  logic [5:0]    band_code;
  logic [FW-1:0] fbm1;

  pll_band_lut #(.FW(FW)) u_band (
    .tgt_khz(tgt_khz), .hit(band_hit), .code(band_code)
  );

  pll_divu #(.NW(NW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(kick_q), .num(num), .den(den),
    .fin(fin), .quo(quo), .rem(rem)
  );

  // divider operands per phase
  always_comb begin
    num = '0;
    den = NW'(1);
    case (st_q)
      S_LO:   begin num = NW'(ref_q); den = NW'(PFD_MAX_KHZ); end
      S_HI:   begin num = NW'(ref_q); den = NW'(PFD_MIN_KHZ); end
      S_VCO:  begin num = NW'(tgt_q); den = NW'(VCO_STEP_KHZ); end
      S_SRCH: begin num = NW'(tgt_q) * NW'(idx_q);   den = NW'(ref_q); end
      S_FIN:  begin num = NW'(tgt_q) * NW'(pbest_q); den = NW'(ref_q); end
      S_RATE: begin num = NW'(ref_q) * NW'(fb_q);    den = NW'(pbest_q); end
      default: ;
    endcase
  end

  assign fbm1 = FW'(quo) - FW'(1);

  always_comb begin
    st_d = st_q;   kick_d = 1'b0;
    tgt_d = tgt_q; ref_d = ref_q; best_d = best_q; fb_d = fb_q;
    pmin_d = pmin_q; pmax_d = pmax_q; idx_d = idx_q; pbest_d = pbest_q;
    erf_d = erf_q; ern_d = ern_q;
    pre_d = pre_q; fbl_d = fbl_q; fbh_d = fbh_q;
    band_d = band_q; vco_d = vco_q; rate_d = rate_q;
    case (st_q)
      S_IDLE: if (start) begin
        tgt_d  = tgt_khz;  ref_d = ref_khz;
        best_d = ref_khz;  pbest_d = PW'(1);
        erf_d  = 1'b0;     pre_d = '0; fbl_d = '0; fbh_d = '0;
        vco_d  = '0;       rate_d = '0;
        band_d = {1'b0, band_code, 1'b0};
        ern_d  = ~band_hit;
        if (band_hit) begin st_d = S_LO; kick_d = 1'b1; end
        else            st_d = S_DONE;
      end
      S_LO: if (fin) begin
        pmin_d = PW'(quo) + PW'(1);
        st_d = S_HI; kick_d = 1'b1;
      end
      S_HI: if (fin) begin
        pmax_d = PW'(quo);
        if (PW'(quo) < pmin_q) begin erf_d = 1'b1; st_d = S_DONE; end
        else begin st_d = S_VCO; kick_d = 1'b1; end
      end
      S_VCO: if (fin) begin
        vco_d = {quo[4:0], 3'b000} | 8'h83;
        kick_d = 1'b1;
        if (pmin_q < pmax_q) begin idx_d = pmin_q; st_d = S_SRCH; end
        else st_d = S_FIN;
      end
      S_SRCH: if (fin) begin
        if (rem < NW'(best_q) && quo < NW'(FB_LIMIT)) begin
          best_d = FW'(rem); pbest_d = idx_q;
        end
        kick_d = 1'b1;
        if (idx_q + PW'(1) < pmax_q) idx_d = idx_q + PW'(1);
        else st_d = S_FIN;
      end
      S_FIN: if (fin) begin
        fb_d  = FW'(quo);
        pre_d = 8'(pbest_q - PW'(1));
        fbl_d = {3'b000, fbm1[4:0]};
        fbh_d = 8'(fbm1 >> 5) | 8'h80;
        st_d = S_RATE; kick_d = 1'b1;
      end
      S_RATE: if (fin) begin
        rate_d = FW'(quo);
        st_d = S_DONE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  kick_q <= 1'b0;
      tgt_q <= '0; ref_q <= '0; best_q <= '0; fb_q <= '0;
      pmin_q <= '0; pmax_q <= '0; idx_q <= '0; pbest_q <= '0;
      erf_q <= 1'b0; ern_q <= 1'b0;
      pre_q <= '0; fbl_q <= '0; fbh_q <= '0;
      band_q <= '0; vco_q <= '0; rate_q <= '0;
    end else begin
      st_q <= st_d;  kick_q <= kick_d;
      tgt_q <= tgt_d; ref_q <= ref_d; best_q <= best_d; fb_q <= fb_d;
      pmin_q <= pmin_d; pmax_q <= pmax_d; idx_q <= idx_d; pbest_q <= pbest_d;
      erf_q <= erf_d; ern_q <= ern_d;
      pre_q <= pre_d; fbl_q <= fbl_d; fbh_q <= fbh_d;
      band_q <= band_d; vco_q <= vco_d; rate_q <= rate_d;
    end
  end

  assign busy       = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done       = (st_q == S_DONE);
  assign err_ref    = erf_q;
  assign err_range  = ern_q;
  assign pre_byte   = pre_q;
  assign fb_lo_byte = fbl_q;
  assign fb_hi_byte = fbh_q;
  assign band_byte  = band_q;
  assign vco_byte   = vco_q;
  assign rate_khz   = rate_q;

endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int unsigned FW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err_ref,
  input logic          err_range,
  input logic [7:0]    fb_lo_byte,
  input logic [7:0]    fb_hi_byte,
  input logic [7:0]    band_byte,
  input logic [7:0]    vco_byte
);

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> (busy || done));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_range) |-> !err_ref);

  // R6
  fb_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_range && !err_ref) |-> (fb_hi_byte[7] && fb_lo_byte[7:5] == 3'b000));

  // R7
  band_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_range) |-> (band_byte[0] == 1'b0 && band_byte[7] == 1'b0));

  // R8
  vco_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_range && !err_ref) |-> (vco_byte[7] && vco_byte[1:0] == 2'b11));

endmodule

bind pll_div_search pll_div_search_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_ref(err_ref), .err_range(err_range), .fb_lo_byte(fb_lo_byte),
  .fb_hi_byte(fb_hi_byte), .band_byte(band_byte), .vco_byte(vco_byte)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;

  localparam int FW = 21;

  typedef struct {
    logic       rng, rfe;
    logic [7:0] pre, fbl, fbh, band, vco;
    longint     rate;
    int         ln;
  } exp_t;

  logic          clk, rst_n, start;
  logic [FW-1:0] tgt_khz, ref_khz;
  logic          busy, done, err_ref, err_range;
  logic [7:0]    pre_byte, fb_lo_byte, fb_hi_byte, band_byte, vco_byte;
  logic [FW-1:0] rate_khz;

  int   n_chk, n_bad, n_popped;
  exp_t sb[$];
  int   lim_t [39] = '{90,100,110,130,140,150,170,180,200,220,240,250,270,300,330,
                       360,400,450,500,550,600,650,700,750,800,850,900,950,1000,
                       1050,1100,1150,1200,1250,1300,1350,1400,1450,1500};
  int   cod_t [39] = '{'h01,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,'h23,
                       'h04,'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,'h18,'h09,
                       'h19,'h29,'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,'h2b,'h3b,'h0c,
                       'h1c,'h2c,'h3c};

  pll_div_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_khz(tgt_khz), .ref_khz(ref_khz),
    .busy(busy), .done(done), .err_ref(err_ref), .err_range(err_range),
    .pre_byte(pre_byte), .fb_lo_byte(fb_lo_byte), .fb_hi_byte(fb_hi_byte),
    .band_byte(band_byte), .vco_byte(vco_byte), .rate_khz(rate_khz)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp, input int ln);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s vector %0d: actual %0h expected %0h", req, ln, act, exp);
    end
  endtask

  function automatic exp_t model(input longint t, input longint r, input int ln);
    exp_t   e;
    longint mn, mx, rem, p, fb;
    int     bi;
    e.ln = ln; e.rng = 1'b0; e.rfe = 1'b0;
    e.pre = 0; e.fbl = 0; e.fbh = 0; e.vco = 0; e.rate = 0; e.band = 0;
    bi = -1;
    for (int k = 38; k >= 0; k--) if (t / 1000 <= lim_t[k]) bi = k;
    if (bi < 0) begin e.rng = 1'b1; return e; end
    e.band = 8'(cod_t[bi] << 1);
    mn = r / 40000 + 1;
    mx = r / 5000;
    if (mx < mn) begin e.rfe = 1'b1; return e; end
    e.vco = 8'(((t / 200000) << 3) | 'h83);
    rem = r; p = 1;
    for (longint i = mn; i < mx; i++)
      if ((t * i) % r < rem && (t * i) / r < 512) begin p = i; rem = (t * i) % r; end
    fb = t * p / r;
    e.pre  = 8'(p - 1);
    e.fbl  = 8'((fb - 1) & 'h1f);
    e.fbh  = 8'((((fb - 1) >> 5) | 'h80) & 'hff);
    e.rate = r * fb / p;
    return e;
  endfunction

  // driver: pushes the expectation, launches, waits for the monitor
  task automatic run(input longint t, input longint r, input int ln);
    int target;
    sb.push_back(model(t, r, ln));
    target = n_popped + 1;
    @(negedge clk);
    tgt_khz = FW'(t); ref_khz = FW'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: launch visible one cycle after start
    chk("R2 launch", longint'(busy | done), 1, ln);
    if (t / 1000 > 1500) chk("R3 early done", longint'(done), 1, ln);
    while (n_popped < target) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      e = sb.pop_front();
      chk("R2 busy low at done", longint'(busy), 0, e.ln);
      chk("R3 err_range", longint'(err_range), longint'(e.rng), e.ln);
      if (!e.rng) begin
        chk("R4 err_ref", longint'(err_ref), longint'(e.rfe), e.ln);
        chk("R7 band", longint'(band_byte), longint'(e.band), e.ln);
        if (!e.rfe) begin
          chk("R5 R10 pre", longint'(pre_byte), longint'(e.pre), e.ln);
          chk("R6 fb lo", longint'(fb_lo_byte), longint'(e.fbl), e.ln);
          chk("R6 fb hi", longint'(fb_hi_byte), longint'(e.fbh), e.ln);
          chk("R8 vco", longint'(vco_byte), longint'(e.vco), e.ln);
          chk("R9 rate", longint'(rate_khz), e.rate, e.ln);
        end
      end
      n_popped++;
      @(negedge clk);
      chk("R2 done one cycle", longint'(done), 0, e.ln);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; n_popped = 0;
    start = 1'b0; tgt_khz = '0; ref_khz = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", longint'(busy), 0, 0);
    chk("R1 done", longint'(done), 0, 0);
    chk("R1 errs", longint'({err_ref, err_range}), 0, 0);
    chk("R1 bytes", longint'({pre_byte, fb_lo_byte, fb_hi_byte, band_byte, vco_byte}), 0, 0);
    chk("R1 rate", longint'(rate_khz), 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(445500,  24000, 1);   // R5 R6 R9 typical
    run(1000000, 24000, 2);
    run(1500000, 24000, 3);   // R7 top band
    run(1500999, 24000, 4);   // R3 inclusive limit
    run(1501000, 24000, 5);   // R3 out of range
    run(90999,   24000, 6);   // R7 first band edge
    run(91000,   24000, 7);   // R7 next band
    run(600000,   5000, 8);   // R10 no candidates
    run(600000,   4999, 9);   // R4 empty window
    run(300000,      0, 10);  // R4 zero reference
    run(750000,  27000, 11);
    run(333000, 100000, 12);  // R5 long window
    run(812345,  38400, 13);
    run(1200000, 52000, 14);
    run(1234567, 19200, 15);  // R8 VCO step 6
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule